// File: doc/BRIEF.md
# Receive Oscillator Reference Selection Controller

This block decides which clock a receive-side digitally controlled oscillator follows in an E1/T1 line interface, and what the oscillator does when no usable reference exists. Two asynchronous reference candidates arrive: the clock recovered from the line and an external sync input. A configuration input picks master or slave behaviour. In slave mode the recovered clock is followed, and a loss-of-signal indication moves the selection over to the sync input unless a disable bit blocks that move. In master mode the sync input is always the reference, and it may run either at the line rate or at a slow 8 kHz frame rate.

Each candidate is watched by a missing-period monitor clocked by a fast system clock. Short gaps of up to three missing periods are bridged, so the oscillator keeps regulating. Four missing periods declare the reference lost. A lost reference has to show two consecutive periods of correct length before it counts as valid again. While the selected reference is not valid, the oscillator is told either to return to its nominal rate or to freeze its present frequency. Every change of the selected source raises a single-cycle pulse, which a downstream phase detector uses to clear its accumulator.

Top module: `refsel_ctrl`

## Requirements
- R1: A selected reference that misses one, two or three consecutive periods (an edge-to-edge gap of at most four nominal periods) keeps `regulate_o` at 1 in every cycle.
- R2: When four or more consecutive periods are missing, the reference is declared lost and `regulate_o` falls to 0.
- R3: `osc_cmd_o` is 0 (track) exactly while regulating. Otherwise it is 1 (return to nominal) when `centre_en_i` is 1, and 2 (freeze) when `centre_en_i` is 0.
- R4: Source codes on `src_sel_o` are 1 for the recovered line clock and 2 for the sync input. Outside reset no other code appears. In slave mode (`master_i`=0) without loss of signal the code is 1.
- R5: In slave mode with `los_i`=1 and `auto_sw_dis_i`=0, the sync input is selected (code 2).
- R6: In slave mode with `auto_sw_dis_i`=1, the line clock stays selected (code 1) whatever `los_i` is.
- R7: In master mode the sync input is selected whatever `los_i` is. With no clock on it the oscillator free-runs (`regulate_o`=0).
- R8: In master mode `sync_8k_i`=1 makes the sync input expected at `SLOW_PERIOD` system clocks, and `sync_8k_i`=0 makes it expected at `LINE_PERIOD`. In slave mode the sync input is always expected at `LINE_PERIOD`.
- R9: A lost reference becomes valid only after two consecutive periods within `LINE_PERIOD`±`TOL` (or the slow period ±`TOL`). Periods outside that window never revalidate it.
- R10: `reselect_o` is high for exactly one cycle, in the cycle `src_sel_o` takes a new value, and is low otherwise.
- R11: During reset `src_sel_o`=0, `regulate_o`=0, `osc_cmd_o`=1 and `reselect_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1 = master mode, 0 = slave mode (quasi-static) |
| auto_sw_dis_i | input | 1 | 1 blocks the slave-mode move to the sync input on loss of signal |
| centre_en_i | input | 1 | 1 = return to nominal rate without a reference, 0 = freeze |
| sync_8k_i | input | 1 | Master-mode sync rate: 0 = line rate, 1 = 8 kHz |
| line_clk_i | input | 1 | Recovered line clock, asynchronous |
| sync_clk_i | input | 1 | External sync clock, asynchronous |
| los_i | input | 1 | Loss of signal, asynchronous |
| src_sel_o | output | 2 | Selected reference: 1 line, 2 sync, 0 only in reset |
| regulate_o | output | 1 | Closed-loop regulation enable |
| osc_cmd_o | output | 2 | 0 track, 1 return to nominal, 2 freeze |
| reselect_o | output | 1 | One-cycle pulse on each source change |

## Verification
The bench sets the gap exactly at the three-period boundary, so a loss threshold that is one period too early drops regulation where it must hold. A four-period gap catches a threshold set too late. Requalification is timed against the third resumed edge, and off-tolerance periods are fed as well: a design that revalidates after one good period, or that accepts wrong lengths, regulates too soon. An exhaustive sweep over mode, loss of signal, disable and centring catches a wrong priority between the disable bit and master mode. A swapped freeze/centre code is caught by the same sweep. Slow-rate sync and pulse counting catch a design that ignores the rate select in master mode, honours it in slave mode, or holds the reselect pulse longer than one cycle.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_LINE = 2'd1,
    SRC_SYNC = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    CMD_TRACK  = 2'd0,
    CMD_CENTRE = 2'd1,
    CMD_FREEZE = 2'd2
  } osc_cmd_e;
endpackage

// File: rtl/refsel_sync.sv
// Multi-stage synchroniser for one asynchronous level.
module refsel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], async_i};
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/refsel_monitor.sv
// Missing-period watcher and requalifier for one reference candidate.
module refsel_monitor #(
  parameter int CW          = 9,
  parameter int TOL         = 1,
  parameter int MISS_LIMIT  = 4,
  parameter int GOOD_NEEDED = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lvl_i,
  input  logic [CW-1:0] period_i,
  output logic          valid_o
);
  localparam int GW = $clog2(GOOD_NEEDED + 1);

  logic          prev;
  logic          rise;
  logic [CW-1:0] since;
  logic [CW-1:0] lost_at;
  logic [CW-1:0] meas;
  logic          in_tol;
  logic [GW-1:0] good;

  assign rise    = lvl_i & ~prev;
  assign lost_at = period_i * CW'(MISS_LIMIT);
  assign meas    = since + CW'(1);
  assign in_tol  = (since < lost_at) &&
                   (meas + CW'(TOL) >= period_i) &&
                   (meas <= period_i + CW'(TOL));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      since   <= '1;
      good    <= '0;
      valid_o <= 1'b0;
    end else begin
      prev <= lvl_i;
      if (rise) begin
        since <= '0;
        if (!valid_o) begin
          if (in_tol) begin
            if (good == GW'(GOOD_NEEDED - 1)) begin
              valid_o <= 1'b1;
              good    <= '0;
            end else begin
              good <= good + GW'(1);
            end
          end else begin
            good <= '0;
          end
        end
      end else begin
        if (since < lost_at) since <= since + CW'(1);
        if (valid_o && since == lost_at - CW'(1)) begin
          valid_o <= 1'b0;
          good    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/refsel_arbiter.sv
// Source choice and registered oscillator commands.
module refsel_arbiter
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       master_i,
  input  logic       auto_sw_dis_i,
  input  logic       centre_en_i,
  input  logic       los_s_i,
  input  logic       line_ok_i,
  input  logic       sync_ok_i,
  output src_e       src_o,
  output logic       regulate_o,
  output osc_cmd_e   cmd_o,
  output logic       reselect_o
);
  src_e src_nxt;
  logic ok_nxt;

  always_comb begin
    if (master_i)                      src_nxt = SRC_SYNC;
    else if (los_s_i && !auto_sw_dis_i) src_nxt = SRC_SYNC;
    else                               src_nxt = SRC_LINE;
    ok_nxt = (src_nxt == SRC_SYNC) ? sync_ok_i : line_ok_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_o      <= SRC_NONE;
      regulate_o <= 1'b0;
      cmd_o      <= CMD_CENTRE;
      reselect_o <= 1'b0;
    end else begin
      src_o      <= src_nxt;
      reselect_o <= (src_nxt != src_o);
      regulate_o <= ok_nxt;
      if (ok_nxt)           cmd_o <= CMD_TRACK;
      else if (centre_en_i) cmd_o <= CMD_CENTRE;
      else                  cmd_o <= CMD_FREEZE;
    end
  end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int LINE_PERIOD = 8,
  parameter int SLOW_PERIOD = 32,
  parameter int TOL         = 1,
  parameter int MISS_LIMIT  = 4,
  parameter int GOOD_NEEDED = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       master_i,
  input  logic       auto_sw_dis_i,
  input  logic       centre_en_i,
  input  logic       sync_8k_i,
  input  logic       line_clk_i,
  input  logic       sync_clk_i,
  input  logic       los_i,
  output logic [1:0] src_sel_o,
  output logic       regulate_o,
  output logic [1:0] osc_cmd_o,
  output logic       reselect_o
);
  localparam int MAXP = (SLOW_PERIOD > LINE_PERIOD) ? SLOW_PERIOD : LINE_PERIOD;
  localparam int CW   = $clog2(MISS_LIMIT * MAXP + TOL + 2) + 1;
  localparam int NIN  = 3;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] syn_in;
  logic [CW-1:0]  per_ref [2];
  logic [1:0]     ok;
  src_e           src;
  osc_cmd_e       cmd;

  assign raw_in = {los_i, sync_clk_i, line_clk_i};

  for (genvar g = 0; g < NIN; g++) begin : g_sync
    refsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_i(raw_in[g]), .sync_o(syn_in[g])
    );
  end

  assign per_ref[0] = CW'(LINE_PERIOD);
  assign per_ref[1] = (master_i && sync_8k_i) ? CW'(SLOW_PERIOD) : CW'(LINE_PERIOD);

  for (genvar g = 0; g < 2; g++) begin : g_mon
    refsel_monitor #(
      .CW(CW), .TOL(TOL), .MISS_LIMIT(MISS_LIMIT), .GOOD_NEEDED(GOOD_NEEDED)
    ) u_mon (
      .clk(clk), .rst(rst), .lvl_i(syn_in[g]), .period_i(per_ref[g]),
      .valid_o(ok[g])
    );
  end

  refsel_arbiter u_arb (
    .clk(clk), .rst(rst), .master_i(master_i), .auto_sw_dis_i(auto_sw_dis_i),
    .centre_en_i(centre_en_i), .los_s_i(syn_in[2]), .line_ok_i(ok[0]),
    .sync_ok_i(ok[1]), .src_o(src), .regulate_o(regulate_o), .cmd_o(cmd),
    .reselect_o(reselect_o)
  );

  assign src_sel_o = src;
  assign osc_cmd_o = cmd;
endmodule

// File: rtl/refsel_ctrl_chk.sv
module refsel_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       master_i,
  input logic       auto_sw_dis_i,
  input logic       centre_en_i,
  input logic [1:0] src_sel_o,
  input logic       regulate_o,
  input logic [1:0] osc_cmd_o,
  input logic       reselect_o
);
  logic run;
  always_ff @(posedge clk) begin
    if (rst) run <= 1'b0;
    else     run <= 1'b1;
  end

  a_r4_src_legal: assert property (@(posedge clk) disable iff (rst)
    run |-> (src_sel_o == 2'd1 || src_sel_o == 2'd2));

  a_r10_reselect_on_change: assert property (@(posedge clk) disable iff (rst)
    run |-> (reselect_o == (src_sel_o != $past(src_sel_o))));

  a_r7_master_sync: assert property (@(posedge clk) disable iff (rst)
    (run && $past(master_i)) |-> src_sel_o == 2'd2);

  a_r6_dis_keeps_line: assert property (@(posedge clk) disable iff (rst)
    (run && $past(!master_i && auto_sw_dis_i)) |-> src_sel_o == 2'd1);

  a_r3_track_when_regulating: assert property (@(posedge clk) disable iff (rst)
    (run && regulate_o) |-> osc_cmd_o == 2'd0);

  a_r3_idle_cmd: assert property (@(posedge clk) disable iff (rst)
    (run && !regulate_o) |-> osc_cmd_o == ($past(centre_en_i) ? 2'd1 : 2'd2));
endmodule

bind refsel_ctrl refsel_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .master_i(master_i), .auto_sw_dis_i(auto_sw_dis_i),
  .centre_en_i(centre_en_i), .src_sel_o(src_sel_o), .regulate_o(regulate_o),
  .osc_cmd_o(osc_cmd_o), .reselect_o(reselect_o)
);

// File: tb/sim_refsel_ctrl.sv
module sim_refsel_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LP = 8;
  localparam int SP = 32;
  localparam int TL = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master = 1'b0, dis = 1'b0, centre = 1'b1, s8k = 1'b0;
  logic line_clk = 1'b0, sync_clk = 1'b0, los = 1'b0;
  logic [1:0] src, cmd;
  logic regulate, reselect;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  bit line_on = 1'b0, sync_on = 1'b0;
  int line_per = LP, sync_per = LP;
  int line_skip = 0, sync_skip = 0;
  bit count_en = 1'b0;
  int pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refsel_ctrl #(.LINE_PERIOD(LP), .SLOW_PERIOD(SP), .TOL(TL)) u0 (
    .clk(clk), .rst(rst), .master_i(master), .auto_sw_dis_i(dis),
    .centre_en_i(centre), .sync_8k_i(s8k), .line_clk_i(line_clk),
    .sync_clk_i(sync_clk), .los_i(los), .src_sel_o(src),
    .regulate_o(regulate), .osc_cmd_o(cmd), .reselect_o(reselect)
  );

  // line clock generator: one period per iteration, optionally skipped
  initial forever begin : gen_line
    int p; bit sk;
    if (!line_on) begin
      @(negedge clk); line_clk = 1'b0;
    end else begin
      p = line_per; sk = (line_skip > 0);
      if (sk) line_skip--;
      for (int i = 0; i < p; i++) begin
        @(negedge clk); line_clk = !sk && (i < p/2);
      end
    end
  end

  initial forever begin : gen_sync
    int p; bit sk;
    if (!sync_on) begin
      @(negedge clk); sync_clk = 1'b0;
    end else begin
      p = sync_per; sk = (sync_skip > 0);
      if (sk) sync_skip--;
      for (int i = 0; i < p; i++) begin
        @(negedge clk); sync_clk = !sk && (i < p/2);
      end
    end
  end

  always @(negedge clk) if (count_en && reselect) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // lowest regulate value seen over n cycles
  task automatic min_reg(input int n, output int m);
    m = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!regulate) m = 0;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int m;
    int exp_src;
    cyc(3);
    // R11 reset state
    chk("R11 src", src, 0);
    chk("R11 regulate", regulate, 0);
    chk("R11 cmd", cmd, 1);
    chk("R11 reselect", reselect, 0);
    rst = 1'b0;

    // exhaustive configuration sweep: R3 R4 R5 R6 R7
    for (int mm = 0; mm < 2; mm++)
      for (int ll = 0; ll < 2; ll++)
        for (int dd = 0; dd < 2; dd++)
          for (int cc = 0; cc < 2; cc++) begin
            master = mm[0]; los = ll[0]; dis = dd[0]; centre = cc[0]; s8k = 1'b0;
            sync_per = LP; line_per = LP;
            line_on = 1'b1; sync_on = 1'b1;
            cyc(10 * LP);
            exp_src = (mm == 1) ? 2 : ((ll == 1 && dd == 0) ? 2 : 1);
            chk("R4/R5/R6/R7 src with clocks", src, exp_src);
            chk("R4 regulate with clocks", regulate, 1);
            chk("R3 track cmd", cmd, 0);
            line_on = 1'b0; sync_on = 1'b0;
            cyc(5 * LP + 20);
            chk("R7 free-run no regulate", regulate, 0);
            chk("R3 idle cmd", cmd, (cc == 1) ? 1 : 2);
          end

    // gap boundaries on the line clock, slave mode
    master = 1'b0; los = 1'b0; dis = 1'b0; centre = 1'b1;
    line_on = 1'b1;
    cyc(10 * LP);
    chk("R9 line valid before gaps", regulate, 1);
    line_skip = 3;
    min_reg(10 * LP, m);
    chk("R1 three missing periods bridged", m, 1);
    cyc(4 * LP);
    line_skip = 4;
    min_reg(10 * LP, m);
    chk("R2 four missing periods lost", m, 0);
    cyc(6 * LP);
    chk("R9 requalified after gap", regulate, 1);

    // requalification timing: needs two good periods
    line_on = 1'b0;
    cyc(6 * LP);
    chk("R2 lost when stopped", regulate, 0);
    line_on = 1'b1;
    cyc(2 * LP);
    chk("R9 not valid after one period", regulate, 0);
    cyc(12);
    chk("R9 valid after two periods", regulate, 1);

    // wrong-length periods never revalidate
    line_on = 1'b0;
    cyc(6 * LP);
    line_per = LP + TL + 2;
    line_on = 1'b1;
    cyc(12 * LP);
    chk("R9 long period rejected", regulate, 0);
    line_per = LP - TL - 2;
    cyc(12 * LP);
    chk("R9 short period rejected", regulate, 0);
    line_per = LP + TL;
    cyc(12 * LP);
    chk("R9 period at tolerance edge accepted", regulate, 1);
    line_per = LP;

    // slow sync rate in master mode
    line_on = 1'b0;
    master = 1'b1; s8k = 1'b1; sync_per = SP; sync_on = 1'b1;
    cyc(6 * SP);
    chk("R8 slow sync accepted in master", regulate, 1);
    sync_skip = 3;
    min_reg(8 * SP, m);
    chk("R1 slow sync three missing bridged", m, 1);
    sync_on = 1'b0;
    cyc(5 * SP + 10);
    sync_per = LP; sync_on = 1'b1;
    cyc(8 * SP);
    chk("R8 line-rate sync rejected in slow mode", regulate, 0);
    master = 1'b0; los = 1'b1; dis = 1'b0;
    cyc(12 * LP);
    chk("R8 slave uses line rate despite select", regulate, 1);
    chk("R5 slave los picks sync", src, 2);
    s8k = 1'b0;

    // reselect pulses
    line_on = 1'b1; los = 1'b0;
    cyc(10 * LP);
    pulses = 0; count_en = 1'b1;
    los = 1'b1; cyc(20);
    los = 1'b0; cyc(20);
    chk("R10 pulses on los toggle", pulses, 2);
    pulses = 0; dis = 1'b1;
    cyc(5);
    los = 1'b1; cyc(20);
    chk("R6 disable keeps line", src, 1);
    los = 1'b0; cyc(20);
    chk("R10 no pulse when disabled", pulses, 0);
    master = 1'b1; cyc(10);
    master = 1'b0; cyc(10);
    chk("R10 pulses on mode toggle", pulses, 2);
    count_en = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule